// File: doc/BRIEF.md
# Up-Counter Channel with Encoded Clear Source

This block is one timer channel. Its up-counter advances once on each prescaled count-enable strobe. It has four general registers, named A, B, C and D. Each register works either as an output-compare register or as an input-capture register. A compare register raises its event when the counter equals its value on a strobe. A capture register stores the counter value on a rising edge of its capture input.

A three-bit clear-select field decides what returns the counter to zero. The field can choose nothing, the event of one general register, or a clear pulse sent by another channel of the same synchronous group. When this channel clears itself from its own source and its sync-enable is set, it sends that clear pulse to the rest of the group.

Registers C and D can be placed in buffer mode. In that mode they produce no events at all. A reduced variant holds only the two low bits of the field. Its top bit is fixed at zero, so C and D cannot be chosen as clear sources.

Top module: `timer_channel`

## Requirements
- R1: After a reset cycle the counter is 0, the clear-select field reads 000, and every match flag, the overflow pulse and the sync-clear output are 0. Every general register resets to all ones.
- R2: The counter rises by one on each clock edge where `cnt_en_i` is 1 and no clear applies. On any other edge it holds its value.
- R3: When no clear applies, the counter wraps from all ones to 0. `ovf_o` is 1 for exactly the cycle in which the counter shows that 0.
- R4: A register in compare mode (`cap_mode_i[n]`=0) has an event on an edge where `cnt_en_i` is 1 and the counter equals the register. `match_o[n]` is 1 in the cycle after that edge.
- R5: A register in capture mode (`cap_mode_i[n]`=1) stores the counter value held before the edge on the first edge after `cap_i[n]` goes from 0 to 1. It also sets `match_o[n]`. Holding `cap_i[n]` high causes no further capture.
- R6: The clear-select code picks the clear source as follows. 000 and 100 mean no clear. 001 means register A, 010 register B, 101 register C and 110 register D (index 0 to 3). On the edge of the chosen register's event, the counter loads 0 instead of incrementing, and no overflow is signalled.
- R7: Codes 011 and 111 clear the counter on an edge where `sync_clr_i` is 1, but only while `sync_en_i` is 1. Under any other code, `sync_clr_i` has no effect.
- R8: When the counter is cleared by this channel's own register event and `sync_en_i` is 1, `sync_clr_o` is 1 for the one cycle in which the counter shows 0. A clear received through `sync_clr_i` does not raise `sync_clr_o`.
- R9: While `buf_c_i` (or `buf_d_i`) is 1, register C (or D) produces no compare event and no capture. It does not set its match flag and it does not clear the counter.
- R10: With `FULL_SEL`=0, bit 2 of the clear-select field always reads 0 and ignores writes. Code 1xx then behaves as code 0xx.
- R11: A register write stores `wdata_i` in each register whose `gr_we_i` bit is set. The value appears on `gr_o` the next cycle, with register n in bits [n*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_i | input | 1 | Prescaled count-enable strobe |
| cap_i | input | 4 | Capture inputs, one per general register |
| cap_mode_i | input | 4 | 1 = capture mode, 0 = compare mode, per register |
| buf_c_i | input | 1 | Register C in buffer mode |
| buf_d_i | input | 1 | Register D in buffer mode |
| gr_we_i | input | 4 | Write enables of the general registers |
| wdata_i | input | CNT_W | Write data for the general registers |
| sel_we_i | input | 1 | Write enable of the clear-select field |
| sel_wdata_i | input | 3 | New clear-select code |
| sync_en_i | input | 1 | Channel takes part in synchronous clearing |
| sync_clr_i | input | 1 | Clear pulse from another channel of the group |
| cnt_o | output | CNT_W | Counter value |
| sel_o | output | 3 | Clear-select field readback |
| gr_o | output | 4*CNT_W | General register values, A in the low bits |
| match_o | output | 4 | Per-register event flags, one cycle |
| ovf_o | output | 1 | Wrap pulse |
| sync_clr_o | output | 1 | Clear pulse sent to the group |

## Verification
The bench builds the channel with `CNT_W`=8. This makes a complete wrap take 256 strobes, so the bench can sweep every compare value of register A and the full overflow boundary, including the case where a clear and a wrap fall on the same edge. Two instances receive the same stimulus: one with `FULL_SEL`=1 and one with `FULL_SEL`=0. The bench sweeps all eight clear codes on both instances and checks that each reduced-variant result equals the full-variant result for the code with bit 2 removed. It also sweeps capture timing over twenty positions.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer channel: clear-select codes and the
// decode helpers that map a code to a clear source.
// Assumes four general registers, indexed A=0, B=1, C=2, D=3.
package tmr_pkg;

    localparam int unsigned GR_COUNT = 4;
    localparam int unsigned SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        CLR_NONE     = 3'b000,
        CLR_ON_A     = 3'b001,
        CLR_ON_B     = 3'b010,
        CLR_GROUP    = 3'b011,
        CLR_NONE_ALT = 3'b100,
        CLR_ON_C     = 3'b101,
        CLR_ON_D     = 3'b110,
        CLR_GROUP_2  = 3'b111
    } clr_sel_e;

    // Returns a one-hot mask of the register whose event clears the counter.
    function automatic logic [GR_COUNT-1:0] own_src_mask(input logic [SEL_W-1:0] code);
        logic [GR_COUNT-1:0] m;
        case (clr_sel_e'(code))
            CLR_ON_A: m = 4'b0001;
            CLR_ON_B: m = 4'b0010;
            CLR_ON_C: m = 4'b0100;
            CLR_ON_D: m = 4'b1000;
            default:  m = 4'b0000;
        endcase
        return m;
    endfunction

    // True when the code makes the counter follow the group clear pulse.
    function automatic logic is_group_code(input logic [SEL_W-1:0] code);
        return (clr_sel_e'(code) == CLR_GROUP) || (clr_sel_e'(code) == CLR_GROUP_2);
    endfunction

endpackage

// File: rtl/tmr_sel_reg.sv
// Clear-select storage. With FULL_SEL=1 it stores all three bits.
// With FULL_SEL=0 the top bit is not stored, reads as zero and drops writes.
// Assumes a synchronous active-low reset to code 000.
module tmr_sel_reg
    import tmr_pkg::*;
#(
    parameter bit FULL_SEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wdata_i,
    output logic [SEL_W-1:0] sel_o
);

    localparam int unsigned LOW_W = SEL_W - 1;

    logic [LOW_W-1:0] low_q;

    // Holds the low bits that every variant keeps.
    always_ff @(posedge clk) begin
        if (!rst_n)    low_q <= '0;
        else if (we_i) low_q <= wdata_i[LOW_W-1:0];
    end

    generate
        if (FULL_SEL) begin : g_full
            logic top_q;
            // Holds the top bit that only the full variant has.
            always_ff @(posedge clk) begin
                if (!rst_n)    top_q <= 1'b0;
                else if (we_i) top_q <= wdata_i[SEL_W-1];
            end
            assign sel_o = {top_q, low_q};
        end else begin : g_reduced
            logic unused_top;
            assign unused_top = wdata_i[SEL_W-1];
            assign sel_o = {1'b0, low_q};
        end
    endgenerate

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(sel_o)); // R10

endmodule

// File: rtl/tmr_gr_slot.sv
// One general register. It either compares against the counter on each
// count strobe or captures the counter on a rising capture edge.
// When BUFFERABLE is set, buffer mode silences every event of this slot.
// A register write takes priority over a capture in the same cycle.
module tmr_gr_slot #(
    parameter int unsigned CNT_W      = 16,
    parameter bit          BUFFERABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             cap_mode_i,
    input  logic             buf_mode_i,
    input  logic             cap_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] gr_o,
    output logic             evt_o
);

    logic             cap_prev_q;
    logic             blocked;
    logic             cap_rise;
    logic             cap_evt;
    logic             cmp_evt;
    logic [CNT_W-1:0] gr_q;

    assign blocked  = BUFFERABLE ? buf_mode_i : 1'b0;
    assign cap_rise = cap_i & ~cap_prev_q;
    assign cap_evt  = cap_mode_i & cap_rise & ~blocked;
    assign cmp_evt  = ~cap_mode_i & cnt_en_i & (cnt_i == gr_q) & ~blocked;
    assign evt_o    = cap_evt | cmp_evt;
    assign gr_o     = gr_q;

    // Remembers the previous capture level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_prev_q <= 1'b0;
        else        cap_prev_q <= cap_i;
    end

    // Updates the register from a write or a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       gr_q <= '1;
        else if (we_i)    gr_q <= wdata_i;
        else if (cap_evt) gr_q <= cnt_i;
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !we_i) |=> (gr_o == $past(cnt_i))); // R5

    AST_CAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && $past(cap_i) && cap_i) |-> !cap_evt); // R5

endmodule

// File: rtl/tmr_counter.sv
// The up-counter. A clear loads zero and overrides the count strobe.
// Without a clear, a strobe at all ones wraps to zero and registers a
// one-cycle overflow pulse that lines up with the zero value.
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Advances, clears or holds the count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr_i)    cnt_q <= '0;
        else if (cnt_en_i) cnt_q <= cnt_q + 1'b1;
    end

    // Flags a wrap that no clear pre-empted.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= cnt_en_i & ~clr_i & (cnt_q == CNT_MAX);
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !clr_i) |=> $stable(cnt_o)); // R2

    AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R6

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o == '0)); // R3

endmodule

// File: rtl/timer_channel.sv
// Timer channel top. Connects the counter, the four general registers and
// the clear-select field. Decodes the clear source and drives the group
// clear pulse. Registers C and D (index 2, 3) are the only ones that can be
// buffered. Assumes cnt_en_i is already prescaled and all inputs are synchronous.
module timer_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter bit          FULL_SEL = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_en_i,
    input  logic [GR_COUNT-1:0]       cap_i,
    input  logic [GR_COUNT-1:0]       cap_mode_i,
    input  logic                      buf_c_i,
    input  logic                      buf_d_i,
    input  logic [GR_COUNT-1:0]       gr_we_i,
    input  logic [CNT_W-1:0]          wdata_i,
    input  logic                      sel_we_i,
    input  logic [SEL_W-1:0]          sel_wdata_i,
    input  logic                      sync_en_i,
    input  logic                      sync_clr_i,
    output logic [CNT_W-1:0]          cnt_o,
    output logic [SEL_W-1:0]          sel_o,
    output logic [GR_COUNT*CNT_W-1:0] gr_o,
    output logic [GR_COUNT-1:0]       match_o,
    output logic                      ovf_o,
    output logic                      sync_clr_o
);

    localparam int unsigned FIRST_BUF = 2;

    logic [GR_COUNT-1:0] buf_vec;
    logic [GR_COUNT-1:0] evt;
    logic [GR_COUNT-1:0] match_q;
    logic [SEL_W-1:0]    sel_q;
    logic [CNT_W-1:0]    cnt;
    logic                own_clr;
    logic                grp_clr;
    logic                clr;
    logic                sync_out_q;

    assign buf_vec = {buf_d_i, buf_c_i, {FIRST_BUF{1'b0}}};

    tmr_sel_reg #(.FULL_SEL(FULL_SEL)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (sel_we_i),
        .wdata_i (sel_wdata_i),
        .sel_o   (sel_q)
    );

    generate
        for (genvar g = 0; g < GR_COUNT; g++) begin : g_slot
            tmr_gr_slot #(
                .CNT_W      (CNT_W),
                .BUFFERABLE (g >= FIRST_BUF)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .we_i       (gr_we_i[g]),
                .wdata_i    (wdata_i),
                .cap_mode_i (cap_mode_i[g]),
                .buf_mode_i (buf_vec[g]),
                .cap_i      (cap_i[g]),
                .cnt_en_i   (cnt_en_i),
                .cnt_i      (cnt),
                .gr_o       (gr_o[g*CNT_W +: CNT_W]),
                .evt_o      (evt[g])
            );
        end
    endgenerate

    assign own_clr = |(own_src_mask(sel_q) & evt);
    assign grp_clr = is_group_code(sel_q) & sync_en_i & sync_clr_i;
    assign clr     = own_clr | grp_clr;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en_i (cnt_en_i),
        .clr_i    (clr),
        .cnt_o    (cnt),
        .ovf_o    (ovf_o)
    );

    // Registers the per-register event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= evt;
    end

    // Sends a group clear only for clears this channel made itself.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out_q <= 1'b0;
        else        sync_out_q <= own_clr & sync_en_i;
    end

    assign cnt_o      = cnt;
    assign sel_o      = sel_q;
    assign match_o    = match_q;
    assign sync_clr_o = sync_out_q;

    AST_SYNC_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_o |-> (cnt_o == '0)); // R8

    AST_SYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en_i |=> !sync_clr_o); // R8

    AST_BUF_C_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_c_i |=> !match_o[2]); // R9

    AST_BUF_D_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_d_i |=> !match_o[3]); // R9

    AST_GROUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr_i && sync_en_i && is_group_code(sel_o)) |=> (cnt_o == '0)); // R7

endmodule

// File: tb/sim_timer_channel.sv
module sim_timer_channel;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cnt_en;
    logic [3:0] cap, cap_mode, gr_we;
    logic buf_c, buf_d, sel_we, sync_en, sync_in;
    logic [W-1:0] wdata;
    logic [2:0] sel_wdata;

    logic [W-1:0] cnt0, cnt1;
    logic [2:0] sel0, sel1;
    logic [4*W-1:0] gr0, gr1;
    logic [3:0] m0, m1;
    logic ovf0, ovf1, so0, so1;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_channel #(.CNT_W(W), .FULL_SEL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .cap_i(cap), .cap_mode_i(cap_mode),
        .buf_c_i(buf_c), .buf_d_i(buf_d), .gr_we_i(gr_we), .wdata_i(wdata),
        .sel_we_i(sel_we), .sel_wdata_i(sel_wdata), .sync_en_i(sync_en), .sync_clr_i(sync_in),
        .cnt_o(cnt0), .sel_o(sel0), .gr_o(gr0), .match_o(m0), .ovf_o(ovf0), .sync_clr_o(so0));

    timer_channel #(.CNT_W(W), .FULL_SEL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .cap_i(cap), .cap_mode_i(cap_mode),
        .buf_c_i(buf_c), .buf_d_i(buf_d), .gr_we_i(gr_we), .wdata_i(wdata),
        .sel_we_i(sel_we), .sel_wdata_i(sel_wdata), .sync_en_i(sync_en), .sync_clr_i(sync_in),
        .cnt_o(cnt1), .sel_o(sel1), .gr_o(gr1), .match_o(m1), .ovf_o(ovf1), .sync_clr_o(so1));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cnt_en = 0; cap = 0; cap_mode = 0; gr_we = 0; buf_c = 0; buf_d = 0;
        sel_we = 0; sync_en = 0; sync_in = 0; wdata = 0; sel_wdata = 0;
        tick();
        rst_n = 1'b1;
    endtask

    task automatic set_gr(input int idx, input int val);
        gr_we = 4'(1 << idx); wdata = W'(val);
        tick();
        gr_we = 0;
    endtask

    task automatic set_sel(input int code);
        sel_we = 1'b1; sel_wdata = 3'(code);
        tick();
        sel_we = 0;
    endtask

    // Clear period for the configuration A=5, B=9, C=3, D=7; 0 means no clear.
    function automatic int period(input int code);
        case (code)
            1: return 6;
            2: return 10;
            5: return 4;
            6: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int expect13(input int code);
        int p;
        p = period(code);
        return (p == 0) ? 13 : 13 % p;
    endfunction

    task automatic load_four();
        set_gr(0, 5); set_gr(1, 9); set_gr(2, 3); set_gr(3, 7);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : main
        int seen;
        // R1 reset state
        do_reset();
        chk("R1 cnt", cnt0, 0); chk("R1 sel", sel0, 0); chk("R1 match", m0, 0);
        chk("R1 ovf", ovf0, 0); chk("R1 sync_out", so0, 0); chk("R1 grA", gr0[W-1:0], 255);

        // R2 hold without strobe, step with strobe
        repeat (3) tick();
        chk("R2 hold", cnt0, 0);
        cnt_en = 1;
        for (int n = 1; n <= 40; n++) begin
            tick();
            chk("R2 step", cnt0, n);
        end
        cnt_en = 0; tick(); tick();
        chk("R2 hold after", cnt0, 40);

        // R3 wrap with clearing disabled
        do_reset(); cnt_en = 1;
        repeat (255) tick();
        chk("R3 at max", cnt0, 255); chk("R3 no ovf yet", ovf0, 0);
        tick();
        chk("R3 wrap", cnt0, 0); chk("R3 ovf", ovf0, 1);
        tick();
        chk("R3 ovf one cycle", ovf0, 0); chk("R3 after wrap", cnt0, 1);

        // R4 R6 sweep every compare value of register A with code 001
        for (int v = 0; v < 256; v++) begin
            do_reset(); set_gr(0, v); set_sel(1); cnt_en = 1;
            repeat (v) tick();
            chk("R4 reach", cnt0, v); chk("R4 no early flag", m0[0], 0);
            tick();
            chk("R6 clear on A", cnt0, 0); chk("R4 flag A", m0[0], 1);
            chk("R6 no ovf on clear", ovf0, 0);
        end

        // R6 R10 all codes on the full and the reduced variant
        for (int code = 0; code < 8; code++) begin
            do_reset(); load_four(); set_sel(code); cnt_en = 1;
            repeat (13) tick();
            chk("R6 code full", cnt0, expect13(code));
            chk("R6 sel full", sel0, code);
            chk("R10 sel reduced", sel1, code & 3);
            chk("R10 cnt reduced", cnt1, expect13(code & 3));
        end

        // R11 write visible
        do_reset(); set_gr(2, 77);
        chk("R11 write C", gr0[2*W +: W], 77);
        chk("R11 others kept", gr0[3*W +: W], 255);

        // R9 buffer mode on C and D
        do_reset(); load_four(); buf_c = 1; set_sel(5); cnt_en = 1; seen = 0;
        repeat (13) begin tick(); seen |= m0[2]; end
        chk("R9 C no clear", cnt0, 13); chk("R9 C no flag", seen, 0);
        do_reset(); load_four(); buf_d = 1; set_sel(6); cnt_en = 1; seen = 0;
        repeat (13) begin tick(); seen |= m0[3]; end
        chk("R9 D no clear", cnt0, 13); chk("R9 D no flag", seen, 0);
        do_reset(); set_gr(2, 3); buf_c = 1; cap_mode = 4'b0100; cnt_en = 1;
        repeat (6) tick();
        cap = 4'b0100; tick();
        chk("R9 no capture", gr0[2*W +: W], 3); chk("R9 no cap flag", m0[2], 0);

        // R5 capture sweep on register A, code 001
        for (int k = 1; k <= 20; k++) begin
            do_reset(); cap_mode = 4'b0001; set_sel(1); cnt_en = 1;
            repeat (k) tick();
            cap = 4'b0001; tick();
            chk("R5 captured", gr0[W-1:0], k); chk("R6 cleared by capture", cnt0, 0);
            chk("R5 flag", m0[0], 1);
            tick();
            chk("R5 level no repeat", m0[0], 0); chk("R5 kept", gr0[W-1:0], k);
            chk("R5 counting", cnt0, 1);
        end

        // R7 group clear
        do_reset(); set_sel(3); sync_en = 1; cnt_en = 1;
        repeat (10) tick();
        sync_in = 1; tick(); sync_in = 0;
        chk("R7 group clear", cnt0, 0); chk("R8 no echo", so0, 0);
        tick();
        sync_en = 0; repeat (5) tick();
        sync_in = 1; tick(); sync_in = 0;
        chk("R7 ignored without enable", cnt0, 7);
        sync_en = 1; set_sel(7);
        sync_in = 1; tick(); sync_in = 0;
        chk("R7 code 111", cnt0, 0);
        set_sel(1);
        sync_in = 1; tick(); sync_in = 0;
        chk("R7 ignored under 001", cnt0, 2);

        // R8 group clear output
        do_reset(); set_gr(0, 5); set_sel(1); sync_en = 1; cnt_en = 1;
        repeat (5) tick();
        chk("R8 idle", so0, 0);
        tick();
        chk("R8 pulse", so0, 1); chk("R8 cnt zero", cnt0, 0);
        tick();
        chk("R8 one cycle", so0, 0);
        sync_en = 0; repeat (4) tick();
        tick();
        chk("R8 clear without enable", cnt0, 0); chk("R8 no pulse", so0, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule